// File: doc/BRIEF.md
# Power-Fail Chip-Enable Conditioner

This block stands between a host's active-low memory chip-enable and up to four battery-backed static memories. While the supply is good, a two-bit address picks which of four active-low enable outputs follows the incoming chip-enable. The other three outputs stay inactive. The address path and the enable path are purely combinational, so the address needs no setup time before the chip-enable falls.

A synchronised supply-valid flag from an external voltage comparator controls write protection. When the flag drops, the block asserts an active-low reset request at once. An access that is already under way may finish, but only for a bounded number of clock cycles. After that, every enable is forced inactive and stays so until the supply returns. On the return of the supply, a recovery counter holds the enables inactive for one programmable period and the reset request for another. Only then does normal operation resume. If the supply fails again during recovery, the block falls back to the protected state, and the count starts over on the next return.

All periods are clock-cycle counts set by parameters. An asynchronous power-on reset places the block in the protected state.

Top module: `pfail_ce_cond`

## Requirements
- R1: While `ceN` is high, all four bits of `ceOutN` are high, whatever `selB`,`selA` hold.
- R2: In normal operation with `ceN` low, `ceOutN` bit index {selB,selA} is low and the other three bits are high (00 drives bit 0, 01 bit 1, 10 bit 2, 11 bit 3).
- R3: If the clock edge that first sees `supplyOk` low also sees `ceN` low (edge 0), the outputs keep following `ceN` through edge `WP_CYC`-1 and are forced all-high after edge `WP_CYC`.
- R4: If `ceN` is seen high at an edge while the supply is failed, all outputs are high after that edge and stay high even if `ceN` falls again, until the supply returns.
- R5: If `ceN` is high at the edge that first sees `supplyOk` low, all outputs are forced high from that edge onward.
- R6: `rstReqN` is low after the first edge that sees `supplyOk` low.
- R7: After the edge that first sees `supplyOk` high again (edge 0), `ceOutN` stays all-high through edge `CE_REC_CYC`-1 regardless of `ceN`, and follows the decode after edge `CE_REC_CYC`.
- R8: After that same edge 0, `rstReqN` stays low through edge `RST_REC_CYC`-1 and goes high after edge `RST_REC_CYC`.
- R9: A supply drop during recovery, while the enables are still held off, returns the block to the protected state. The next return restarts both recovery periods from zero.
- R10: While `rstN` is low, `ceOutN` is all-high and `rstReqN` is low, and after `rstN` is released the block stays protected until `supplyOk` is seen high.
- R11: A change of `selB`,`selA` made together with the fall of `ceN` shows on `ceOutN` without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all periods count its rising edges |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| supplyOk | input | 1 | Synchronised supply-valid flag, high when the supply is in tolerance |
| ceN | input | 1 | Incoming active-low chip-enable |
| selA | input | 1 | Low bit of the output select |
| selB | input | 1 | High bit of the output select |
| ceOutN | output | 4 | Conditioned active-low chip-enables, one per memory |
| rstReqN | output | 1 | Active-low reset request to the host |

## Verification
The decoder is driven with each of the four select codes under a low chip-enable, and with a high chip-enable over several codes, so that a swapped bit, a wrong polarity or a missing gate gives a different output word. The address and the chip-enable are changed in the same instant and sampled before any clock edge, which separates a combinational path from a registered one. Supply drops are applied three ways: with the enable idle, with an access left running until the timeout, and with an access ended early. These three cases tell apart immediate protection, the bounded drain and the latch-off after an early end. The recovery counts are checked one edge before and one edge at each boundary, and a drop part-way through recovery shows whether the count restarts.

// File: rtl/pfce_pkg.sv
package pfce_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfState_e;

  // strobes from the control FSM to the gating datapath
  typedef struct packed {
    logic gateOff;   // force every conditioned enable inactive
    logic rstLow;    // drive the reset request active
  } pfCtrl_t;
endpackage

// File: rtl/pfce_ctrl.sv
module pfce_ctrl
  import pfce_pkg::*;
#(
  parameter int WP_CYC      = 100,
  parameter int CE_REC_CYC  = 80000,
  parameter int RST_REC_CYC = 100000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyOk,
  input  logic    ceN,
  output pfCtrl_t ctrl
);
  localparam int REC_MAX = (CE_REC_CYC > RST_REC_CYC) ? CE_REC_CYC : RST_REC_CYC;
  localparam int CNT_MAX = (WP_CYC > REC_MAX) ? WP_CYC : REC_MAX;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WP_LAST = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] CE_LIM  = CW'(CE_REC_CYC);
  localparam logic [CW-1:0] RST_LIM = CW'(RST_REC_CYC);
  localparam logic [CW-1:0] REC_LIM = CW'(REC_MAX);

  pfState_e state, stateNxt;
  logic [CW-1:0] tick, tickNxt;

  // strobes depend only on registered state
  always_comb begin
    unique case (state)
      ST_NORMAL:  begin ctrl.gateOff = 1'b0; ctrl.rstLow = 1'b0; end
      ST_DRAIN:   begin ctrl.gateOff = 1'b0; ctrl.rstLow = 1'b1; end
      ST_PROTECT: begin ctrl.gateOff = 1'b1; ctrl.rstLow = 1'b1; end
      default: begin
        ctrl.gateOff = (tick < CE_LIM);
        ctrl.rstLow  = (tick < RST_LIM);
      end
    endcase
  end

  always_comb begin
    stateNxt = state;
    tickNxt  = tick;
    unique case (state)
      ST_NORMAL: begin
        tickNxt = '0;
        if (!supplyOk) stateNxt = ceN ? ST_PROTECT : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (ceN || tick == WP_LAST) begin
          stateNxt = ST_PROTECT;
          tickNxt  = '0;
        end else begin
          tickNxt = tick + 1'b1;
        end
      end
      ST_PROTECT: begin
        tickNxt = '0;
        if (supplyOk) stateNxt = ST_RECOVER;
      end
      default: begin
        if (!supplyOk) begin
          // an access already released by recovery may drain
          stateNxt = (!ctrl.gateOff && !ceN) ? ST_DRAIN : ST_PROTECT;
          tickNxt  = '0;
        end else if (tick >= REC_LIM) begin
          stateNxt = ST_NORMAL;
          tickNxt  = '0;
        end else begin
          tickNxt = tick + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_PROTECT;
      tick  <= '0;
    end else begin
      state <= stateNxt;
      tick  <= tickNxt;
    end
  end
endmodule

// File: rtl/pfce_gate.sv
module pfce_gate
  import pfce_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  pfCtrl_t                 ctrl,
  input  logic                    ceN,
  input  logic [SEL_W-1:0]        sel,
  output logic [(1<<SEL_W)-1:0]   ceOutN,
  output logic                    rstReqN
);
  localparam int NUM_OUT = 1 << SEL_W;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign ceOutN[i] = ceN | ctrl.gateOff | (sel != SEL_W'(i));
  end

  assign rstReqN = ~ctrl.rstLow;
endmodule

// File: rtl/pfail_ce_cond.sv
module pfail_ce_cond
  import pfce_pkg::*;
#(
  parameter int WP_CYC      = 100,
  parameter int CE_REC_CYC  = 80000,
  parameter int RST_REC_CYC = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       ceN,
  input  logic       selA,
  input  logic       selB,
  output logic [3:0] ceOutN,
  output logic       rstReqN
);
  pfCtrl_t ctrl;

  pfce_ctrl #(
    .WP_CYC(WP_CYC),
    .CE_REC_CYC(CE_REC_CYC),
    .RST_REC_CYC(RST_REC_CYC)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .supplyOk(supplyOk),
    .ceN(ceN),
    .ctrl(ctrl)
  );

  pfce_gate #(.SEL_W(2)) u_gate (
    .ctrl(ctrl),
    .ceN(ceN),
    .sel({selB, selA}),
    .ceOutN(ceOutN),
    .rstReqN(rstReqN)
  );
endmodule

// File: rtl/pfce_chk.sv
module pfce_chk #(
  parameter int WP_CYC = 100
) (
  input logic       clk,
  input logic       rstN,
  input logic       supplyOk,
  input logic       ceN,
  input logic [3:0] ceOutN,
  input logic       rstReqN
);
  // cycles the outputs stayed live while the supply was failed
  logic [31:0] liveFail;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveFail <= '0;
    else if (!supplyOk && ceOutN != 4'hF) begin
      if (liveFail != 32'hFFFF_FFFF) liveFail <= liveFail + 1;
    end else liveFail <= '0;
  end

  a_r1_idle_all_high: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> ceOutN == 4'hF);

  a_r2_one_active: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ceOutN));

  a_r3_drain_bounded: assert property (@(posedge clk) disable iff (!rstN)
    liveFail <= 32'(WP_CYC + 1));

  a_r5_idle_fail_protects: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && ceN) |=> ceOutN == 4'hF);

  a_r6_reset_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyOk) |=> !rstReqN);

  a_r7_hold_after_return: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(supplyOk) && ceN) |=> (ceOutN == 4'hF && !rstReqN));
endmodule

bind pfail_ce_cond pfce_chk #(.WP_CYC(WP_CYC)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .supplyOk(supplyOk),
  .ceN(ceN),
  .ceOutN(ceOutN),
  .rstReqN(rstReqN)
);

// File: tb/pfail_ce_cond_tb.sv
module pfail_ce_cond_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WP  = 8;
  localparam int CER = 20;
  localparam int RSR = 30;

  logic clk = 1'b0;
  logic rstN, supplyOk, ceN, selA, selB;
  logic [3:0] ceOutN;
  logic rstReqN;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfail_ce_cond #(.WP_CYC(WP), .CE_REC_CYC(CER), .RST_REC_CYC(RST_REC_CYC_T)) u_dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .ceN(ceN),
    .selA(selA), .selB(selB), .ceOutN(ceOutN), .rstReqN(rstReqN)
  );
  localparam int RST_REC_CYC_T = RSR;

  task automatic chk4(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ceOutN actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s rstReqN actual=%b expected=%b", req, act, exp);
    end
  endtask

  // pass n rising edges, then settle 1 time unit after the last
  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] dec(logic [1:0] s);
    return ~(4'b0001 << s);
  endfunction

  // supply returns with an access pending on select 0
  task automatic t_recover(string tag);
    edges(1);
    supplyOk = 1'b1; ceN = 1'b0; {selB, selA} = 2'b00;
    edges(CER);
    chk4({tag, " R7 held before limit"}, ceOutN, 4'hF);
    edges(1);
    chk4({tag, " R7 released at limit"}, ceOutN, dec(2'b00));
    chk1({tag, " R8 still low"}, rstReqN, 1'b0);
    edges(RSR - CER - 1);
    chk1({tag, " R8 low before limit"}, rstReqN, 1'b0);
    edges(1);
    chk1({tag, " R8 high at limit"}, rstReqN, 1'b1);
    ceN = 1'b1;
    edges(2);
  endtask

  task automatic t_reset();
    rstN = 1'b0; supplyOk = 1'b0; ceN = 1'b0; {selB, selA} = 2'b01;
    #(CLK_PERIOD*3);
    chk4("R10 reset outputs", ceOutN, 4'hF);
    chk1("R10 reset request", rstReqN, 1'b0);
    rstN = 1'b1;
    edges(4);
    chk4("R10 protected after reset", ceOutN, 4'hF);
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      ceN = 1'b1; #2;
      {selB, selA} = 2'(s); ceN = 1'b0;  // R11 same instant
      #1;
      chk4($sformatf("R2 R11 select %0d", s), ceOutN, dec(2'(s)));
    end
    for (int s = 0; s < 4; s++) begin
      {selB, selA} = 2'(s); ceN = 1'b1; #1;
      chk4($sformatf("R1 idle select %0d", s), ceOutN, 4'hF);
    end
    edges(1);
  endtask

  task automatic t_drain_timeout();
    ceN = 1'b0; {selB, selA} = 2'b10; supplyOk = 1'b0;
    edges(1);
    chk1("R6 reset on drop", rstReqN, 1'b0);
    chk4("R3 drain live", ceOutN, dec(2'b10));
    edges(WP - 1);
    chk4("R3 live before timeout", ceOutN, dec(2'b10));
    edges(1);
    chk4("R3 forced at timeout", ceOutN, 4'hF);
    edges(5);
    chk4("R3 stays forced", ceOutN, 4'hF);
  endtask

  task automatic t_drain_early();
    ceN = 1'b0; {selB, selA} = 2'b11; supplyOk = 1'b0;
    edges(3);
    chk4("R3 early drain live", ceOutN, dec(2'b11));
    ceN = 1'b1;
    edges(1);
    ceN = 1'b0; #1;
    chk4("R4 latched after access end", ceOutN, 4'hF);
    edges(WP + 2);
    chk4("R4 still latched", ceOutN, 4'hF);
    ceN = 1'b1;
  endtask

  task automatic t_idle_drop();
    ceN = 1'b1; supplyOk = 1'b0;
    edges(1);
    ceN = 1'b0; {selB, selA} = 2'b01; #1;
    chk4("R5 idle drop protects", ceOutN, 4'hF);
    chk1("R6 idle drop reset", rstReqN, 1'b0);
    ceN = 1'b1;
  endtask

  task automatic t_drop_in_recovery();
    edges(1);
    supplyOk = 1'b1; ceN = 1'b1;
    edges(6);
    supplyOk = 1'b0;
    edges(1);
    ceN = 1'b0; #1;
    chk4("R9 protected after drop", ceOutN, 4'hF);
    edges(CER);
    chk4("R9 stays protected", ceOutN, 4'hF);
    chk1("R9 reset held", rstReqN, 1'b0);
    t_recover("R9 restart");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_recover("power-up");
    t_decode();
    t_drain_timeout();
    t_recover("after timeout");
    t_drain_early();
    t_recover("after early end");
    t_idle_drop();
    t_drop_in_recovery();
    t_decode();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule